// File: doc/BRIEF.md
# Logarithmic-Domain Adder

The block returns the logarithm of a sum when it is given the logarithms of the two addends. Operands and result are 16-bit signed fixed-point natural-log values with 8 fractional bits. It first puts the operands in order, so the larger one becomes the base. It then subtracts the smaller from the base to get a non-negative gap d. A constant correction ln(1 + e^-d) is looked up for that gap and added to the base.

A small controller steps through subtract, lookup and add. Both arithmetic steps run through one shared integer add/subtract unit. The correction values are fixed logic, not a memory.

A caller raises `start_i` for one cycle while the block is idle, with the operands on `log_a_i` and `log_b_i`. It then waits for the one-cycle `done_o` pulse. `result_o` keeps that value until the next operation completes.

Top module: `logadd_unit`

## Requirements
- R1: While reset is applied, and on the first cycle after it is released, `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: A `start_i` sampled high at a clock edge while idle makes `busy_o` high after that edge. `done_o` rises after the third edge following it and stays high for exactly one cycle. `busy_o` falls with `done_o`.
- R3: For a gap d = max − min (in units of 1/256) below 2048, the result is max + C(d). C(d) = round(256 · ln(1 + e^(−0.25·k))), with k = floor(d / 64), rounding half up.
- R4: For a gap of 2048 or more, the correction is zero and the result equals the larger operand exactly. This includes gaps wider than 16 bits, such as 32767 and −32768.
- R5: Swapping the two operands gives the same result.
- R6: A sum above 32767 saturates to 32767. The result is never below the larger operand.
- R7: A `start_i` raised while `busy_o` is high is ignored. The pending result belongs to the accepted operands, and only one `done_o` pulse appears.
- R8: While idle with `start_i` low, `result_o` holds its last value.
- R9: Equal operands give the operand plus 177 (ln 2 in the Q8.8 format).
- R10: The table index is bits [10:6] of the gap. The gap 63 uses entry 0 (177) and the gap 64 uses entry 1 (147).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| log_a_i | input | 16 | First operand, signed Q8.8 log value |
| log_b_i | input | 16 | Second operand, signed Q8.8 log value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| result_o | output | 16 | Signed Q8.8 log of the sum |

## Verification
Operand ordering is the state most likely to be wrong. If it is reversed, the gap wraps to a huge value and the correction silently drops to zero. Putting every vector in both orders exposes this at the first `done_o`. A controller that skips or repeats a step moves the `done_o` pulse off its third-edge slot, or leaves `busy_o` high, and this shows within four cycles of `start`. A wrong table entry or index slice shows as a result that is off by a few LSBs. The bench catches it with gaps on both sides of each 64-unit bin edge. An overflowing add shows as a negative result for two large positive operands.

// File: rtl/logadd_pkg.sv
package logadd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SUB    = 3'd1,
    ST_LOOKUP = 3'd2,
    ST_ADD    = 3'd3,
    ST_DONE   = 3'd4
  } lad_state_t;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SUB = 1'b1
  } lad_alu_op_t;
endpackage

// File: rtl/logadd_alu.sv
module logadd_alu #(
  parameter int AW = 17
) (
  input  logic [AW-1:0]           opa_i,
  input  logic [AW-1:0]           opb_i,
  input  logadd_pkg::lad_alu_op_t op_i,
  output logic [AW-1:0]           res_o
);
  import logadd_pkg::*;

  logic [AW-1:0] opb_eff;
  logic          cin;

  always_comb begin
    opb_eff = (op_i == ALU_SUB) ? ~opb_i : opb_i;
    cin     = (op_i == ALU_SUB);
  end

  assign res_o = opa_i + opb_eff + {{(AW-1){1'b0}}, cin};
endmodule

// File: rtl/logadd_corr_rom.sv
module logadd_corr_rom #(
  parameter int GW   = 11,
  parameter int IDXW = 5,
  parameter int CW   = 8
) (
  input  logic [GW-1:0] gap_hi_i,
  output logic [CW-1:0] corr_o
);
  localparam int FARW = GW - IDXW;

  logic            far;
  logic [IDXW-1:0] idx;

  assign idx = gap_hi_i[IDXW-1:0];

  generate
    if (FARW > 0) begin : g_far
      assign far = |gap_hi_i[GW-1:IDXW];
    end else begin : g_nofar
      assign far = 1'b0;
    end
  endgenerate

  function automatic logic [7:0] entry(input logic [IDXW-1:0] k);
    case (k)
      5'd0:  entry = 8'd177;
      5'd1:  entry = 8'd147;
      5'd2:  entry = 8'd121;
      5'd3:  entry = 8'd99;
      5'd4:  entry = 8'd80;
      5'd5:  entry = 8'd64;
      5'd6:  entry = 8'd52;
      5'd7:  entry = 8'd41;
      5'd8:  entry = 8'd32;
      5'd9:  entry = 8'd26;
      5'd10: entry = 8'd20;
      5'd11: entry = 8'd16;
      5'd12: entry = 8'd12;
      5'd13: entry = 8'd10;
      5'd14: entry = 8'd8;
      5'd15: entry = 8'd6;
      5'd16: entry = 8'd5;
      5'd17: entry = 8'd4;
      5'd18: entry = 8'd3;
      5'd19: entry = 8'd2;
      5'd20: entry = 8'd2;
      5'd21: entry = 8'd1;
      5'd22: entry = 8'd1;
      5'd23: entry = 8'd1;
      5'd24: entry = 8'd1;
      default: entry = 8'd0;
    endcase
  endfunction

  always_comb begin
    corr_o = far ? '0 : CW'(entry(idx));
  end
endmodule

// File: rtl/logadd_ctrl.sv
module logadd_ctrl (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  output logadd_pkg::lad_state_t   state_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     ld_ops_o,
  output logic                     ld_gap_o,
  output logic                     ld_corr_o,
  output logic                     ld_res_o,
  output logadd_pkg::lad_alu_op_t  alu_op_o
);
  import logadd_pkg::*;

  lad_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SUB;
      ST_SUB:    state_d = ST_LOOKUP;
      ST_LOOKUP: state_d = ST_ADD;
      ST_ADD:    state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    ld_ops_o  = (state_q == ST_IDLE) && start_i;
    ld_gap_o  = (state_q == ST_SUB);
    ld_corr_o = (state_q == ST_LOOKUP);
    ld_res_o  = (state_q == ST_ADD);
    alu_op_o  = (state_q == ST_SUB) ? ALU_SUB : ALU_ADD;
    busy_o    = (state_q != ST_IDLE);
    done_o    = (state_q == ST_DONE);
    state_o   = state_q;
  end

  assert_done_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_accept_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_SUB));
  assert_ignore_busy_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (state_q != ST_SUB));
endmodule

// File: rtl/logadd_unit.sv
module logadd_unit #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int IDXW = 5,
  parameter int CW   = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] log_a_i,
  input  logic [W-1:0] log_b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  import logadd_pkg::*;

  localparam int AW     = W + 1;
  localparam int SHIFT  = FRAC - 2;
  localparam int GW     = AW - SHIFT;
  localparam int SPAN   = 1 << (SHIFT + IDXW);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  lad_state_t  state;
  lad_alu_op_t alu_op;
  logic        ld_ops, ld_gap, ld_corr, ld_res;

  logadd_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .start_i  (start_i),
    .state_o  (state),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .ld_ops_o (ld_ops),
    .ld_gap_o (ld_gap),
    .ld_corr_o(ld_corr),
    .ld_res_o (ld_res),
    .alu_op_o (alu_op)
  );

  logic [W-1:0]  base_q, other_q, result_q;
  logic [AW-1:0] gap_q;
  logic [CW-1:0] corr_q;
  logic          a_ge_b;
  logic [W-1:0]  base_d, other_d;

  always_comb begin
    a_ge_b  = ($signed(log_a_i) >= $signed(log_b_i));
    base_d  = a_ge_b ? log_a_i : log_b_i;
    other_d = a_ge_b ? log_b_i : log_a_i;
  end

  logic [AW-1:0] alu_a, alu_b, alu_res;

  always_comb begin
    alu_a = {base_q[W-1], base_q};
    if (alu_op == ALU_SUB) alu_b = {other_q[W-1], other_q};
    else                   alu_b = {{(AW-CW){1'b0}}, corr_q};
  end

  logadd_alu #(.AW(AW)) u_alu (
    .opa_i(alu_a),
    .opb_i(alu_b),
    .op_i (alu_op),
    .res_o(alu_res)
  );

  logic [CW-1:0] corr_d;

  logadd_corr_rom #(.GW(GW), .IDXW(IDXW), .CW(CW)) u_rom (
    .gap_hi_i(gap_q[AW-1:SHIFT]),
    .corr_o  (corr_d)
  );

  logic          ovf;
  logic [W-1:0]  sum_sat;

  always_comb begin
    ovf     = !alu_res[AW-1] && alu_res[W-1];
    sum_sat = ovf ? POS_MAX : alu_res[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      other_q <= '0;
    end else if (ld_ops) begin
      base_q  <= base_d;
      other_q <= other_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (ld_gap) gap_q <= alu_res;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       corr_q <= '0;
    else if (ld_corr) corr_q <= corr_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (ld_res) result_q <= sum_sat;
  end

  assign result_o = result_q;

  assert_not_below_base_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> ($signed(result_q) >= $signed(base_q)));
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && !base_q[W-1]) |-> !result_q[W-1]);
  assert_far_gap_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == ST_LOOKUP && gap_q >= AW'(SPAN)) |=> (corr_q == '0));
  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(result_o));
endmodule

// File: tb/logadd_unit_bench.sv
module logadd_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  localparam logic [31:0] VECS [NV] = '{
    {16'sd0,      16'sd0},
    {16'sd256,    16'sd0},
    {16'sd0,      16'sd256},
    {-16'sd512,   -16'sd512},
    {16'sd1000,   16'sd900},
    {16'sd100,    -16'sd100},
    {-16'sd3000,  -16'sd2990},
    {16'sd2047,   16'sd0},
    {16'sd2048,   16'sd0},
    {16'sd32767,  -16'sd32768},
    {16'sd32767,  16'sd32767},
    {16'sd32700,  16'sd32690},
    {-16'sd32768, -16'sd32768},
    {16'sd64,     16'sd0},
    {16'sd63,     16'sd0},
    {-16'sd700,   16'sd500}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] a, b;
  logic        busy, done;
  logic [15:0] result;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logadd_unit u_logadd_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .log_a_i(a), .log_b_i(b),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  function automatic int model(input int x, input int y);
    int mx, mn, d, c, r;
    mx = (x > y) ? x : y;
    mn = (x > y) ? y : x;
    d  = mx - mn;
    if (d >= 2048) c = 0;
    else c = $rtoi(256.0 * $ln(1.0 + $exp(-0.25 * real'(d / 64))) + 0.5);
    r = mx + c;
    if (r > 32767) r = 32767;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] x, input logic [15:0] y, input string req);
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    @(negedge clk);
    @(negedge clk);
    check("R2 no early done", done, 0);
    @(negedge clk);
    check("R2 done on third edge", done, 1);
    check(req, $signed(result), model($signed(x), $signed(y)));
    @(negedge clk);
    check("R2 done one cycle", done, 0);
    check("R2 busy falls", busy, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; start = 1'b0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 result in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", busy, 0);
    check("R1 result after release", result, 0);
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i][31:16], VECS[i][15:0], "R3 R4 R6 R9 R10 vector");
      run_op(VECS[i][15:0], VECS[i][31:16], "R5 swapped vector");
    end

    run_op(16'sd10, 16'sd10, "R9 equal operands");
    check("R9 ln2 offset", $signed(result), 187);
    run_op(16'sd63, 16'sd0, "R10 bin 0");
    check("R10 entry 0", $signed(result), 63 + 177);
    run_op(16'sd64, 16'sd0, "R10 bin 1");
    check("R10 entry 1", $signed(result), 64 + 147);
    run_op(16'sd32767, 16'sd32767, "R6 saturate");
    check("R6 saturated value", $signed(result), 32767);
    run_op(-16'sd32768, 16'sd32767, "R4 widest gap");
    check("R4 base only", $signed(result), 32767);

    // R7: start while busy is ignored
    @(negedge clk);
    a = 16'sd300; b = 16'sd300; start = 1'b1;
    @(negedge clk);
    a = 16'sd5000; b = -16'sd5000;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R7 done for first op", done, 1);
    check("R7 result of first op", $signed(result), 477);
    @(negedge clk);
    check("R7 no second done", done, 0);
    check("R7 idle again", busy, 0);

    // R8: hold while idle
    held = result;
    a = 16'sd1234; b = 16'sd77;
    repeat (5) @(negedge clk);
    check("R8 result held", result, held);
    check("R8 no done while idle", done, 0);

    // R1: reset mid-operation
    @(negedge clk);
    a = 16'sd256; b = 16'sd256; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 busy cleared", busy, 0);
    check("R1 result cleared", result, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_op(16'sd256, 16'sd256, "R3 after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule